// File: doc/BRIEF.md
# I2C Register-Write Slave for a Multi-Channel DAC

This block is the serial front end of a multi-channel DAC register bank. It oversamples the I2C clock and data lines with a fast system clock, cleans them with a synchronizer and a short glitch filter, and recognises START and STOP conditions on the filtered lines. It answers to one 7-bit address. The top five bits of that address are fixed at `10101`. The two low bits are picked by a three-level strap pin.

A write carries three bytes after the address: a command byte, a data high byte and a data low byte. Once the third byte is acknowledged, the block emits the 24-bit word on a one-cycle strobe for the register bank to decode. A read returns a 16-bit readback value, high byte first, and the master may cut it short with a NACK. The block drives SDA as an open-drain pull-down enable. It supports standard-mode and fast-mode bus speeds whenever the system clock is much faster than SCL.

Top module: `i2c_dac_slave`

## Requirements
- R1: The slave address is `10101` followed by two strap bits. The `addr_pin` encoding is `00` for the strap tied low, which gives low bits `11`; `01` for the strap tied high, which gives `00`; and `1x` for the strap floating, which gives `10`. Only a matching address byte is acknowledged.
- R2: A START (SDA falls while SCL is high) begins a fresh address phase, including when it arrives in the middle of a transfer. A STOP (SDA rises while SCL is high) returns the block to idle and releases SDA.
- R3: Bytes are taken in MSB first. The slave acknowledges by pulling SDA low for the whole ninth SCL pulse of a matched address byte and of every write data byte.
- R4: After the acknowledge of the third write data byte, `frame_valid` is high for exactly one cycle. `frame_word` is then `{command, data_high, data_low}` and holds that value until the next frame.
- R5: The slave changes its SDA drive only while SCL is low.
- R6: Write bytes after the third are acknowledged and discarded. They cause no second strobe and no change to `frame_word`.
- R7: On a read (R/W bit = 1), the slave captures `rd_data` when the address acknowledge ends. It then sends bits [15:8] followed by bits [7:0], MSB first. A master NACK ends the read and SDA stays released. Any byte the master asks for beyond the second reads as `FF`.
- R8: The general-call address `0000000` and 10-bit address prefixes `11110xx` are not acknowledged. Nor is any later byte before the next START.
- R9: A pulse on SCL shorter than `FILT` system clocks is ignored.
- R10: Out of reset, `sda_oe` and `frame_valid` are 0 and `frame_word` is 0.
- R11: A write that stops after fewer than three data bytes produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pin | input | 2 | Strap state: 00 tied low, 01 tied high, 1x floating |
| rd_data | input | 16 | Value returned by a read |
| sda_oe | output | 1 | 1 pulls the SDA pad low |
| frame_valid | output | 1 | One-cycle strobe for a completed write frame |
| frame_word | output | 24 | Last complete frame {command, data high, data low} |

## Verification
Some properties are checked by assertions on every cycle:
- the SDA drive changes only while the filtered SCL is low;
- the frame strobe lasts a single cycle and lands in an SCL-low phase;
- SDA is released after a STOP;
- SDA is never driven while the block is idle or ignoring the bus.

Other behaviour can only be shown by the bench's transactions: the address match for each strap setting, the byte order of the frame word, the readback order and the early NACK, the rejection of general-call and 10-bit prefixes, extra and missing bytes, repeated START, and the immunity of the filter to glitches.

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave #(
  parameter int          FILT    = 3,
  parameter logic [4:0]  ADDR_HI = 5'b10101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  addr_pin,
  input  logic [15:0] rd_data,
  output logic        sda_oe,
  output logic        frame_valid,
  output logic [23:0] frame_word
);
  localparam int CW = $clog2(FILT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;

  logic [1:0]    s1, s2, filt, filt_q;
  logic [CW-1:0] fc [2];
  st_t           st;
  logic          is_addr, rw, nack, rcnt, pend;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, lsb_q;
  logic [1:0]    wcnt;
  logic [23:0]   acc;
  logic [1:0]    lo;
  logic [6:0]    my_addr;
  logic          scl_rise, scl_fall, start_e, stop_e, idle;

  assign lo       = addr_pin[1] ? 2'b10 : (addr_pin[0] ? 2'b00 : 2'b11);
  assign my_addr  = {ADDR_HI, lo};
  assign scl_rise = filt[0] & ~filt_q[0];
  assign scl_fall = ~filt[0] & filt_q[0];
  assign start_e  = filt[0] & filt_q[0] & filt_q[1] & ~filt[1];
  assign stop_e   = filt[0] & filt_q[0] & ~filt_q[1] & filt[1];
  assign idle     = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; filt <= 2'b11; filt_q <= 2'b11;
      for (int i = 0; i < 2; i++) fc[i] <= '0;
    end else begin
      s1 <= {sda_i, scl_i};
      s2 <= s1;
      filt_q <= filt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] != filt[i]) begin
          if (fc[i] == CW'(FILT - 1)) begin
            filt[i] <= s2[i];
            fc[i]   <= '0;
          end else begin
            fc[i] <= fc[i] + 1'b1;
          end
        end else begin
          fc[i] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; is_addr <= 1'b0; rw <= 1'b0; nack <= 1'b0; rcnt <= 1'b0;
      pend <= 1'b0; bitcnt <= '0; sh <= '0; lsb_q <= '0; wcnt <= '0; acc <= '0;
      sda_oe <= 1'b0; frame_valid <= 1'b0; frame_word <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (start_e) begin
        st <= ST_RX; is_addr <= 1'b1; bitcnt <= '0; sda_oe <= 1'b0;
        wcnt <= '0; pend <= 1'b0;
      end else if (stop_e) begin
        st <= ST_IDLE; sda_oe <= 1'b0; pend <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], filt[1]};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (is_addr) begin
                if (sh[7:1] == my_addr) begin
                  rw <= sh[0]; sda_oe <= 1'b1; st <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                if (wcnt != 2'd3) begin
                  acc  <= {acc[15:0], sh};
                  wcnt <= wcnt + 1'b1;
                  pend <= (wcnt == 2'd2);
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_addr && rw) begin
                st     <= ST_TX;
                sh     <= rd_data[15:8];
                lsb_q  <= rd_data[7:0];
                sda_oe <= ~rd_data[15];
                rcnt   <= 1'b0;
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
              is_addr <= 1'b0;
              if (pend) begin
                frame_valid <= 1'b1;
                frame_word  <= acc;
                pend        <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b1};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) nack <= filt[1];
            if (scl_fall) begin
              if (nack) begin
                st <= ST_IDLE;
              end else begin
                st     <= ST_TX;
                bitcnt <= '0;
                sh     <= rcnt ? 8'hFF : lsb_q;
                sda_oe <= rcnt ? 1'b0 : ~lsb_q[7];
                rcnt   <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_dac_slave_chk.sv
module i2c_dac_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic frame_valid,
  input logic stop_e,
  input logic idle
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f); // R5
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R4
  AST_STROBE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !scl_f); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_e |=> !sda_oe); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe); // R8
endmodule

bind i2c_dac_slave i2c_dac_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(filt[0]), .sda_oe(sda_oe),
  .frame_valid(frame_valid), .stop_e(stop_e), .idle(idle)
);

// File: tb/sim_i2c_dac_slave.sv
module sim_i2c_dac_slave;
  localparam int Q = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_pin = 2'b01;
  logic [15:0] rd_data = 16'h0;
  logic sda_oe, frame_valid;
  logic [23:0] frame_word;
  logic line;
  int n_run = 0, n_fail = 0, fv_cnt = 0;
  logic [23:0] fv_word = '0;
  logic done = 1'b0;

  assign line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  i2c_dac_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
    .addr_pin(addr_pin), .rd_data(rd_data), .sda_oe(sda_oe),
    .frame_valid(frame_valid), .frame_word(frame_word));

  always @(negedge clk) if (frame_valid) begin fv_cnt++; fv_word = frame_word; end

  // {pin[1:0], addr[6:0], cmd, msb, lsb, expect_ack}
  localparam logic [33:0] VEC [6] = '{
    {2'b01, 7'b1010100, 24'h301234, 1'b1},
    {2'b10, 7'b1010110, 24'h3FABCD, 1'b1},
    {2'b00, 7'b1010111, 24'h01FF00, 1'b1},
    {2'b01, 7'b1010111, 24'h112233, 1'b0},
    {2'b00, 7'b1010100, 24'h445566, 1'b0},
    {2'b11, 7'b1010110, 24'h000001, 1'b1}
  };

  task automatic wc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s: actual %h expected %h", req, act, exp); end
  endtask

  task automatic bit_io(input logic b, output logic smp, input bit glitch = 0);
    sda_m = b; wc(Q/2);
    if (glitch) begin scl_m = 1'b1; wc(1); scl_m = 1'b0; end
    wc(Q/2);
    scl_m = 1'b1; wc(Q); smp = line; wc(Q); scl_m = 1'b0;
  endtask

  task automatic start_c(); sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b0; wc(Q); scl_m = 1'b0; endtask
  task automatic stop_c(); wc(Q); sda_m = 1'b0; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b1; wc(2*Q); endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack, input bit glitch = 0);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s, glitch && i == 4);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, s); b = {b[6:0], s}; end
    bit_io(~mack, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int f0;
    wc(5);
    chk(sda_oe == 0 && frame_valid == 0 && frame_word == 0, "R10 reset", {sda_oe, frame_valid, frame_word}, 0);
    rst_n = 1'b1; wc(10);

    for (int v = 0; v < 6; v++) begin
      addr_pin = VEC[v][33:32];
      f0 = fv_cnt;
      start_c();
      wr_byte({VEC[v][31:25], 1'b0}, ack);
      chk(ack == VEC[v][0], "R1 address ack", ack, VEC[v][0]);
      wr_byte(VEC[v][24:17], ack); chk(ack == VEC[v][0], "R3 cmd ack", ack, VEC[v][0]);
      wr_byte(VEC[v][16:9], ack);  chk(ack == VEC[v][0], "R3 msb ack", ack, VEC[v][0]);
      wr_byte(VEC[v][8:1], ack);   chk(ack == VEC[v][0], "R3 lsb ack", ack, VEC[v][0]);
      stop_c();
      chk(fv_cnt == f0 + (VEC[v][0] ? 1 : 0), "R4 strobe count", fv_cnt - f0, VEC[v][0]);
      if (VEC[v][0]) chk(fv_word == VEC[v][24:1], "R4 frame word", fv_word, VEC[v][24:1]);
      chk(sda_oe == 0, "R2 released after stop", sda_oe, 0);
    end

    addr_pin = 2'b01;
    // R6: fourth byte acked and dropped
    f0 = fv_cnt;
    start_c(); wr_byte(8'hA8, ack);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack); wr_byte(8'h33, ack);
    wr_byte(8'h44, ack); chk(ack == 1, "R6 extra byte ack", ack, 1);
    stop_c();
    chk(fv_cnt == f0 + 1, "R6 single strobe", fv_cnt - f0, 1);
    chk(frame_word == 24'h112233, "R6 word unchanged", frame_word, 24'h112233);

    // R11: short frame
    f0 = fv_cnt;
    start_c(); wr_byte(8'hA8, ack); wr_byte(8'h55, ack); wr_byte(8'h66, ack); stop_c();
    chk(fv_cnt == f0, "R11 no strobe", fv_cnt - f0, 0);

    // R2: repeated start mid frame
    f0 = fv_cnt;
    start_c(); wr_byte(8'hA8, ack); wr_byte(8'h99, ack);
    start_c(); wr_byte(8'hA8, ack); chk(ack == 1, "R2 restart ack", ack, 1);
    wr_byte(8'h0A, ack); wr_byte(8'h0B, ack); wr_byte(8'h0C, ack); stop_c();
    chk(fv_cnt == f0 + 1 && fv_word == 24'h0A0B0C, "R2 restart frame", fv_word, 24'h0A0B0C);

    // R9: short SCL glitch
    start_c(); wr_byte(8'hA8, ack);
    wr_byte(8'h5C, ack, 1'b1); wr_byte(8'h6D, ack, 1'b1); wr_byte(8'h7E, ack); stop_c();
    chk(fv_word == 24'h5C6D7E, "R9 glitch ignored", fv_word, 24'h5C6D7E);

    // R7: full read
    rd_data = 16'hA55A;
    start_c(); wr_byte(8'hA9, ack); chk(ack == 1, "R7 read addr ack", ack, 1);
    rd_byte(1'b1, b); chk(b == 8'hA5, "R7 high byte", b, 8'hA5);
    rd_byte(1'b1, b); chk(b == 8'h5A, "R7 low byte", b, 8'h5A);
    rd_byte(1'b0, b); chk(b == 8'hFF, "R7 beyond second", b, 8'hFF);
    stop_c();

    // R7: early NACK
    rd_data = 16'h0F30;
    start_c(); wr_byte(8'hA9, ack);
    rd_byte(1'b0, b); chk(b == 8'h0F, "R7 high byte nack", b, 8'h0F);
    rd_byte(1'b0, b); chk(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    stop_c();

    // R8: general call and 10-bit prefix
    start_c(); wr_byte(8'h00, ack); chk(ack == 0, "R8 general call", ack, 0);
    wr_byte(8'hA8, ack); chk(ack == 0, "R8 ignore until start", ack, 0);
    stop_c();
    start_c(); wr_byte(8'hF2, ack); chk(ack == 0, "R8 10-bit prefix", ack, 0);
    wr_byte(8'h00, ack); chk(ack == 0, "R8 10-bit follow byte", ack, 0);
    stop_c();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule